// File: doc/BRIEF.md
# ATM Receive Cell Header Filter

This block sits in an ATM receive path after header error checking. It takes the header of each cell one byte per accepted beat, starting at a cell-start strobe. After the fourth header byte it reports, in a single registered pulse, whether the cell is to be forwarded or dropped. Payload bytes pass it by without effect. Payload storage is left to the stage that acts on the decision.

Three fixed classes of header are recognised: idle, unassigned and invalid. Each class has its own configuration bit that makes it pass or drop. A programmable 32-bit pattern and mask add a header comparator. Its two-bit mode picks whether matching or non-matching cells are of interest, and whether they are only counted or counted and dropped. Two saturating counters record unassigned cells removed by the filter and comparator hits. A synchronous clear input zeroes both counters.

Top module: `atm_cell_filter`

## Requirements
- R1: A beat with `byte_valid` and `cell_start` both high carries header bit 31..24. The next three beats with `byte_valid` high and `cell_start` low carry bits 23..16, 15..8 and 7..0. Beats that come after the fourth header byte and before the next `cell_start` produce no decision and change no counter. A `cell_start` in the middle of a header discards the partial header.
- R2: `dec_valid` is high for exactly one cycle, the cycle after the clock edge that accepts the fourth header byte. `dec_keep` is 1 in that cycle if the cell is forwarded and 0 if it is dropped. `dec_keep` is 0 whenever `dec_valid` is 0.
- R3: The idle header is exactly 0x00000001. An idle cell is dropped when `cfg_idle_pass` is 0 and forwarded when it is 1.
- R4: A header is unassigned when bits 27..4 (path and channel identifiers) are all zero and bit 0 (loss priority) is 0. Bits 31..28 and 3..1 are ignored for this test. With `cfg_unas_drop` = 1 an unassigned cell is dropped and `unas_count` goes up by one. With `cfg_unas_drop` = 0 the class has no effect on the decision or on `unas_count`.
- R5: A header is invalid when bits 27..4 are zero, bits 3..0 are not zero, and the header is not the idle header. With `cfg_inv_drop` = 1 an invalid cell is dropped. With 0 the class has no effect.
- R6: A header matches when ((header XOR `cfg_pattern`) AND `cfg_mask`) is zero. A mask bit of 0 makes that header bit a don't-care.
- R7: `cfg_cmp_mode` 00 counts matching cells in `cmp_count`. Mode 01 counts non-matching cells. Neither mode drops the cell.
- R8: `cfg_cmp_mode` 10 counts and drops matching cells. Mode 11 counts and drops non-matching cells.
- R9: A cell is forwarded only when no enabled rule (R3, R4, R5, R8) asks for a drop. Configuration is sampled on the edge that accepts the fourth header byte.
- R10: Each counter stops at 2^CNT_W-1 and never wraps.
- R11: `cnt_clr` zeroes both counters on the next clock edge. It takes priority over an increment on the same edge.
- R12: After `rst`, `dec_valid`, `dec_keep` and both counters are 0, and no partial header is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_clr | input | 1 | Synchronous clear of both counters |
| byte_valid | input | 1 | A byte is present on `byte_data` |
| cell_start | input | 1 | This byte is the first header byte |
| byte_data | input | 8 | Cell stream byte |
| cfg_idle_pass | input | 1 | 1 forwards idle cells |
| cfg_unas_drop | input | 1 | 1 counts and drops unassigned cells |
| cfg_inv_drop | input | 1 | 1 drops invalid cells |
| cfg_cmp_mode | input | 2 | Comparator mode: bit 1 drops, bit 0 selects non-match |
| cfg_pattern | input | 32 | Header compare pattern |
| cfg_mask | input | 32 | Header compare mask, 1 = bit compared |
| dec_valid | output | 1 | Decision pulse |
| dec_keep | output | 1 | 1 = forward the cell |
| unas_count | output | CNT_W | Dropped unassigned cell count |
| cmp_count | output | CNT_W | Comparator hit count |

## Verification
A wrong byte index in the header collector shows up in the next cell. Either the decision pulse lands on the wrong beat, it appears during payload, or it is missing altogether. A wrong header assembly gives the wrong class, so `dec_keep` is wrong in that same decision cycle. A counter that wraps or misses its clear shows a wrong value one cycle after the edge in question. The bench checks `dec_keep` and both counts on every decision cycle and at every payload beat. With a narrow counter width, saturation is reached many times during the run.

// File: rtl/atm_filt_pkg.sv
package atm_filt_pkg;
  localparam int BYTE_W    = 8;
  localparam int HDR_BYTES = 4;
  localparam int HDR_W     = BYTE_W * HDR_BYTES;
  // identifier field (path + channel) position in the header word
  localparam int ID_LSB    = 4;
  localparam int ID_MSB    = 27;
  localparam int PTC_W     = 4;
  localparam logic [HDR_W-1:0] IDLE_HDR = HDR_W'(1);

  typedef enum logic [1:0] {
    CMP_CNT_HIT  = 2'b00,
    CMP_CNT_MISS = 2'b01,
    CMP_DROP_HIT = 2'b10,
    CMP_DROP_MISS= 2'b11
  } cmp_mode_e;

  typedef struct packed {
    logic idle;
    logic unas;
    logic inval;
    logic match;
  } cell_class_t;
endpackage

// File: rtl/atm_filt_hdr_collect.sv
module atm_filt_hdr_collect
  import atm_filt_pkg::*;
#(
  parameter int BW = BYTE_W,
  parameter int NB = HDR_BYTES
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            byte_valid,
  input  logic            cell_start,
  input  logic [BW-1:0]   byte_data,
  output logic [BW*NB-1:0] hdr_next,
  output logic            hdr_last
);
  localparam int HW    = BW * NB;
  localparam int IDX_W = $clog2(NB + 1);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NB - 1);

  logic [IDX_W-1:0] idx;
  logic [HW-1:0]    shreg;

  assign hdr_last = byte_valid && !cell_start && (idx == LAST_IDX);
  assign hdr_next = {shreg[HW-BW-1:0], byte_data};

  always_ff @(posedge clk) begin
    if (rst) begin
      idx   <= '0;
      shreg <= '0;
    end else if (byte_valid && cell_start) begin
      idx   <= IDX_W'(1);
      shreg <= HW'(byte_data);
    end else if (byte_valid && idx != '0) begin
      shreg <= {shreg[HW-BW-1:0], byte_data};
      idx   <= (idx == LAST_IDX) ? '0 : idx + IDX_W'(1);
    end
  end
endmodule

// File: rtl/atm_filt_classify.sv
module atm_filt_classify
  import atm_filt_pkg::*;
(
  input  logic [HDR_W-1:0] hdr,
  input  logic [HDR_W-1:0] pattern,
  input  logic [HDR_W-1:0] mask,
  output cell_class_t      cls
);
  logic id_zero;
  assign id_zero   = (hdr[ID_MSB:ID_LSB] == '0);
  assign cls.idle  = (hdr == IDLE_HDR);
  assign cls.unas  = id_zero && !hdr[0];
  assign cls.inval = id_zero && (hdr[PTC_W-1:0] != '0) && !cls.idle;
  assign cls.match = (((hdr ^ pattern) & mask) == '0);
endmodule

// File: rtl/atm_filt_sat_cnt.sv
module atm_filt_sat_cnt #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt
);
  localparam logic [W-1:0] TOP = {W{1'b1}};
  always_ff @(posedge clk) begin
    if (rst || clr)
      cnt <= '0;
    else if (inc && cnt != TOP)
      cnt <= cnt + W'(1);
  end
endmodule

// File: rtl/atm_cell_filter.sv
module atm_cell_filter
  import atm_filt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cnt_clr,
  input  logic              byte_valid,
  input  logic              cell_start,
  input  logic [BYTE_W-1:0] byte_data,
  input  logic              cfg_idle_pass,
  input  logic              cfg_unas_drop,
  input  logic              cfg_inv_drop,
  input  logic [1:0]        cfg_cmp_mode,
  input  logic [HDR_W-1:0]  cfg_pattern,
  input  logic [HDR_W-1:0]  cfg_mask,
  output logic              dec_valid,
  output logic              dec_keep,
  output logic [CNT_W-1:0]  unas_count,
  output logic [CNT_W-1:0]  cmp_count
);
  logic [HDR_W-1:0] hdr_next;
  logic             hdr_last;
  cell_class_t      cls;
  cmp_mode_e        mode;
  logic             cmp_hit, drop, unas_inc, cmp_inc;

  atm_filt_hdr_collect #(.BW(BYTE_W), .NB(HDR_BYTES)) u_collect (
    .clk(clk), .rst(rst), .byte_valid(byte_valid), .cell_start(cell_start),
    .byte_data(byte_data), .hdr_next(hdr_next), .hdr_last(hdr_last)
  );

  atm_filt_classify u_classify (
    .hdr(hdr_next), .pattern(cfg_pattern), .mask(cfg_mask), .cls(cls)
  );

  assign mode    = cmp_mode_e'(cfg_cmp_mode);
  assign cmp_hit = (mode == CMP_CNT_MISS || mode == CMP_DROP_MISS) ? !cls.match : cls.match;

  always_comb begin
    drop = 1'b0;
    if (cls.idle && !cfg_idle_pass) drop = 1'b1;
    if (cls.unas && cfg_unas_drop)  drop = 1'b1;
    if (cls.inval && cfg_inv_drop)  drop = 1'b1;
    if (cmp_hit && (mode == CMP_DROP_HIT || mode == CMP_DROP_MISS)) drop = 1'b1;
  end

  assign unas_inc = hdr_last && cls.unas && cfg_unas_drop;
  assign cmp_inc  = hdr_last && cmp_hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      dec_valid <= 1'b0;
      dec_keep  <= 1'b0;
    end else begin
      dec_valid <= hdr_last;
      dec_keep  <= hdr_last && !drop;
    end
  end

  atm_filt_sat_cnt #(.W(CNT_W)) u_unas_cnt (
    .clk(clk), .rst(rst), .clr(cnt_clr), .inc(unas_inc), .cnt(unas_count)
  );

  atm_filt_sat_cnt #(.W(CNT_W)) u_cmp_cnt (
    .clk(clk), .rst(rst), .clr(cnt_clr), .inc(cmp_inc), .cnt(cmp_count)
  );
endmodule

// File: rtl/atm_cell_filter_chk.sv
module atm_cell_filter_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             cnt_clr,
  input logic             hdr_last,
  input logic             dec_valid,
  input logic             dec_keep,
  input logic [CNT_W-1:0] unas_count,
  input logic [CNT_W-1:0] cmp_count
);
  localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

  AST_DEC_AFTER_LAST: assert property (@(posedge clk) disable iff (rst) hdr_last |=> dec_valid); // R2
  AST_NO_STRAY_DEC:   assert property (@(posedge clk) disable iff (rst) !hdr_last |=> !dec_valid); // R1
  AST_KEEP_GATED:     assert property (@(posedge clk) disable iff (rst) dec_keep |-> dec_valid); // R2
  AST_UNAS_SAT:       assert property (@(posedge clk) disable iff (rst) (unas_count == TOP && !cnt_clr) |=> unas_count == TOP); // R10
  AST_CMP_SAT:        assert property (@(posedge clk) disable iff (rst) (cmp_count == TOP && !cnt_clr) |=> cmp_count == TOP); // R10
  AST_CLR_ZERO:       assert property (@(posedge clk) disable iff (rst) cnt_clr |=> (unas_count == '0 && cmp_count == '0)); // R11
  AST_UNAS_QUIET:     assert property (@(posedge clk) disable iff (rst) (!cnt_clr && !hdr_last) |=> $stable(unas_count)); // R4
  AST_CMP_QUIET:      assert property (@(posedge clk) disable iff (rst) (!cnt_clr && !hdr_last) |=> $stable(cmp_count)); // R7
  AST_CMP_STEP:       assert property (@(posedge clk) disable iff (rst) !cnt_clr |=> (cmp_count - $past(cmp_count)) <= CNT_W'(1)); // R10
endmodule

bind atm_cell_filter atm_cell_filter_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .cnt_clr(cnt_clr), .hdr_last(hdr_last),
  .dec_valid(dec_valid), .dec_keep(dec_keep),
  .unas_count(unas_count), .cmp_count(cmp_count)
);

// File: tb/atm_cell_filter_test.sv
`timescale 1ns/1ps
module atm_cell_filter_test;
  localparam int CW = 4;
  localparam int MAXC = (1 << CW) - 1;

  logic clk = 1'b0;
  logic rst, cnt_clr, byte_valid, cell_start;
  logic [7:0] byte_data;
  logic cfg_idle_pass, cfg_unas_drop, cfg_inv_drop;
  logic [1:0] cfg_cmp_mode;
  logic [31:0] cfg_pattern, cfg_mask;
  logic dec_valid, dec_keep;
  logic [CW-1:0] unas_count, cmp_count;

  int n_chk = 0, n_fail = 0;
  int m_unas = 0, m_cmp = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  atm_cell_filter #(.CNT_W(CW)) uut (
    .clk(clk), .rst(rst), .cnt_clr(cnt_clr), .byte_valid(byte_valid),
    .cell_start(cell_start), .byte_data(byte_data),
    .cfg_idle_pass(cfg_idle_pass), .cfg_unas_drop(cfg_unas_drop),
    .cfg_inv_drop(cfg_inv_drop), .cfg_cmp_mode(cfg_cmp_mode),
    .cfg_pattern(cfg_pattern), .cfg_mask(cfg_mask),
    .dec_valid(dec_valid), .dec_keep(dec_keep),
    .unas_count(unas_count), .cmp_count(cmp_count)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit f_idle(logic [31:0] h);  return h == 32'h1; endfunction
  function automatic bit f_unas(logic [31:0] h);  return h[27:4] == 0 && !h[0]; endfunction
  function automatic bit f_inv(logic [31:0] h);   return h[27:4] == 0 && h[3:0] != 0 && !f_idle(h); endfunction
  function automatic bit f_hit(logic [31:0] h);
    bit m = ((h ^ cfg_pattern) & cfg_mask) == 0;   // R6
    return cfg_cmp_mode[0] ? !m : m;               // R7
  endfunction
  function automatic bit f_keep(logic [31:0] h);   // R9
    if (f_idle(h) && !cfg_idle_pass) return 0;     // R3
    if (f_unas(h) && cfg_unas_drop) return 0;      // R4
    if (f_inv(h) && cfg_inv_drop) return 0;        // R5
    if (f_hit(h) && cfg_cmp_mode[1]) return 0;     // R8
    return 1;
  endfunction

  task automatic send_cell(logic [31:0] h, bit gaps, int npay, bit clr_last, string tag);
    bit k = f_keep(h);
    bit ui = f_unas(h) && cfg_unas_drop;
    bit ci = f_hit(h);
    for (int b = 0; b < 4; b++) begin
      @(negedge clk);
      if (gaps && ($urandom % 3 == 0)) begin
        byte_valid = 0; cell_start = 0;
        @(negedge clk);
      end
      byte_valid = 1;
      cell_start = (b == 0);
      byte_data  = h[31 - 8*b -: 8];
      cnt_clr    = clr_last && (b == 3);
    end
    @(negedge clk);
    byte_valid = 0; cell_start = 0; cnt_clr = 0;
    if (clr_last) begin
      m_unas = 0; m_cmp = 0;                      // R11
    end else begin
      if (ui && m_unas < MAXC) m_unas++;          // R10
      if (ci && m_cmp < MAXC) m_cmp++;
    end
    check({tag, " R2 dec_valid"}, 32'(dec_valid), 1);
    check({tag, " R9 dec_keep"}, 32'(dec_keep), 32'(k));
    check({tag, " R4 unas_count"}, 32'(unas_count), 32'(m_unas));
    check({tag, " R7 cmp_count"}, 32'(cmp_count), 32'(m_cmp));
    for (int p = 0; p < npay; p++) begin
      byte_valid = 1; cell_start = 0; byte_data = 8'($urandom);
      @(negedge clk);
      check({tag, " R1 payload no decision"}, {dec_valid, dec_keep}, 0);
      check({tag, " R1 payload counts"}, {unas_count, cmp_count}, {m_unas[CW-1:0], m_cmp[CW-1:0]});
    end
    byte_valid = 0;
  endtask

  function automatic logic [31:0] pick_hdr();
    case ($urandom % 6)
      0: return 32'h1;
      1: return {4'($urandom), 24'h0, 3'($urandom), 1'b0};
      2: return {4'($urandom), 24'h0, 4'($urandom % 15 + 1)};
      3: return (cfg_pattern & cfg_mask) | ($urandom & ~cfg_mask);
      default: return $urandom;
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rst = 1; cnt_clr = 0; byte_valid = 0; cell_start = 0; byte_data = 0;
    cfg_idle_pass = 0; cfg_unas_drop = 0; cfg_inv_drop = 0; cfg_cmp_mode = 0;
    cfg_pattern = 0; cfg_mask = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check("R12 reset outputs", {dec_valid, dec_keep, unas_count, cmp_count}, 0);

    // R3: idle dropped then passed; mask 0 => every cell matches, mode 00 counts
    send_cell(32'h1, 0, 2, 0, "R3 idle drop");
    cfg_idle_pass = 1;
    send_cell(32'h1, 0, 0, 0, "R3 idle pass");
    // R4: unassigned with GFC/PT set
    cfg_unas_drop = 1;
    send_cell(32'hA000_0006, 1, 1, 0, "R4 unassigned drop");
    cfg_unas_drop = 0;
    send_cell(32'hA000_0006, 0, 0, 0, "R4 unassigned pass");
    // R5: invalid, including nonzero GFC with idle-like low bits
    cfg_inv_drop = 1;
    send_cell(32'h5000_0001, 0, 0, 0, "R5 invalid drop");
    cfg_inv_drop = 0;
    send_cell(32'h0000_0009, 0, 0, 0, "R5 invalid pass");
    // R8: drop on match / on miss
    cfg_pattern = 32'h0123_4560; cfg_mask = 32'hFFFF_FFF0; cfg_cmp_mode = 2'b10;
    send_cell(32'h0123_456F, 0, 0, 0, "R8 drop match");
    cfg_cmp_mode = 2'b11;
    send_cell(32'h0123_456F, 0, 0, 0, "R8 miss not dropped");
    send_cell(32'h0223_4560, 0, 0, 0, "R8 drop miss");
    // R1: partial header abandoned by a new cell_start
    @(negedge clk);
    byte_valid = 1; cell_start = 1; byte_data = 8'h00;
    @(negedge clk);
    cell_start = 0; byte_data = 8'h00;
    @(negedge clk);
    byte_valid = 0;
    check("R1 partial no decision", 32'(dec_valid), 0);
    cfg_cmp_mode = 2'b01;
    send_cell(32'h0123_4561, 0, 0, 0, "R1 restart");
    // R11: clear on same edge as an increment
    cfg_cmp_mode = 2'b00; cfg_mask = 0;
    send_cell(32'h1234_5678, 0, 0, 1, "R11 clr priority");
    // R10: saturate comparator counter
    for (int i = 0; i < MAXC + 3; i++) send_cell($urandom, 0, 0, 0, "R10 saturate");

    // random mix
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      cfg_idle_pass = 1'($urandom); cfg_unas_drop = 1'($urandom);
      cfg_inv_drop = 1'($urandom); cfg_cmp_mode = 2'($urandom);
      if ($urandom % 8 == 0) begin
        cfg_pattern = $urandom; cfg_mask = $urandom;
      end
      send_cell(pick_hdr(), 1'($urandom), $urandom % 4, ($urandom % 40 == 0), "R9 random");
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule